// File: doc/BRIEF.md
# Lockable Comparator Control Register Bank

This block holds the configuration of two analog comparators in two 32-bit control and status words. Word 0 is at byte offset 0x00 and word 1 is at byte offset 0x04. A plain synchronous bus reaches both words. It has an address, write data and a write strobe, and read data that follows the address combinationally. The stored fields go straight to the signal-conditioning path.

The fields cover the following:
- channel enable
- inverting and non-inverting input selectors
- window-mode input sharing
- window-output XOR selection
- output polarity
- hysteresis level
- power/speed mode
- a one-hot blanking source selector

Bit 30 of each word is not stored. It shows the live conditioned comparator output that comes in on `stat_i`.

Each word has a self-locking bit at position 31. Once a write sets it, that word stops taking writes until the next reset, and the lock bit itself is frozen too. This protects a safety-related setup from stray bus traffic. The two words lock independently.

Top module: `cmp_ctrl_regs`

## Requirements
- R1: After reset every stored field and both lock bits are 0, and both words read back 0 while `stat_i` is 0.
- R2: A write to an unlocked word stores its fields at the following positions, and the word and the exported outputs show them after the write edge:
  - 24:20 blanking select
  - 19:18 power mode
  - 17:16 hysteresis
  - 15 polarity
  - 14 window output
  - 11 window mode
  - 10:8 non-inverting select
  - 7:4 inverting select
  - 0 enable
- R3: In word 1 the non-inverting selector is only bits 9:8. Bit 10 reads 0, and the exported selector's top bit for channel 1 stays 0.
- R4: Writing 1 to bit 31 sets that word's lock. No later write clears it, and only reset does.
- R5: While a word is locked, writes to it change no bit of that word and no exported field of that channel.
- R6: The write that sets the lock also stores all other fields carried in the same write.
- R7: Locking one word leaves the other word writable.
- R8: Bit 30 of word i always reads the live `stat_i[i]`, and writes to bit 30 have no effect.
- R9: Bits 29:25, 13:12 and 3:1 of both words read 0 whatever is written.
- R10: Reads from any address other than 0x00 and 0x04 return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| stat_i | input | 2 | Live conditioned comparator outputs |
| en_o | output | 2 | Enable per channel |
| inp_sel_o | output | 6 | Non-inverting selector, 3 bits per channel |
| inm_sel_o | output | 8 | Inverting selector, 4 bits per channel |
| win_mode_o | output | 2 | Window-mode input sharing per channel |
| win_out_o | output | 2 | Window XOR output select per channel |
| pol_o | output | 2 | Output polarity per channel |
| hyst_o | output | 4 | Hysteresis, 2 bits per channel |
| pwr_o | output | 4 | Power mode, 2 bits per channel |
| blank_o | output | 10 | Blanking source select, 5 bits per channel |
| lock_o | output | 2 | Lock state per channel |

## Verification
A write takes effect at the clock edge where the strobe is high. The stored fields, the exported outputs and the lock are all due one edge after the stimulus. Read data and bit 30 are combinational, so they are due in the same cycle as the address or status change.

The bench drives all inputs on the falling edge. For writes, it compares results at the next falling edge, after the single capturing rising edge. For reads and status changes, it compares results a short delay after setting the address or status, before any rising edge.

// File: rtl/cmp_regs_pkg.sv
package cmp_regs_pkg;
  localparam int NUM_CH    = 2;
  localparam int WORD_W    = 32;
  localparam int INP_MAX_W = 3;
  localparam int INM_W     = 4;
  localparam int BLANK_W   = 5;

  localparam int LOCK_BIT  = 31;
  localparam int STAT_BIT  = 30;
  localparam int BLANK_LSB = 20;
  localparam int PWR_LSB   = 18;
  localparam int HYST_LSB  = 16;
  localparam int POL_BIT   = 15;
  localparam int WOUT_BIT  = 14;
  localparam int WMODE_BIT = 11;
  localparam int INP_LSB   = 8;
  localparam int INM_LSB   = 4;
  localparam int EN_BIT    = 0;

  typedef struct packed {
    logic [BLANK_W-1:0]   blank;
    logic [1:0]           pwr;
    logic [1:0]           hyst;
    logic                 pol;
    logic                 win_out;
    logic                 win_mode;
    logic [INP_MAX_W-1:0] inp;
    logic [INM_W-1:0]     inm;
    logic                 en;
  } cfg_t;

  function automatic logic [WORD_W-1:0] pack_word(cfg_t c, logic lk, logic st);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LOCK_BIT]                   = lk;
    w[STAT_BIT]                   = st;
    w[BLANK_LSB +: BLANK_W]       = c.blank;
    w[PWR_LSB +: 2]               = c.pwr;
    w[HYST_LSB +: 2]              = c.hyst;
    w[POL_BIT]                    = c.pol;
    w[WOUT_BIT]                   = c.win_out;
    w[WMODE_BIT]                  = c.win_mode;
    w[INP_LSB +: INP_MAX_W]       = c.inp;
    w[INM_LSB +: INM_W]           = c.inm;
    w[EN_BIT]                     = c.en;
    return w;
  endfunction
endpackage

// File: rtl/cmp_addr_dec.sv
module cmp_addr_dec #(
  parameter int ADDR_W = 8,
  parameter int NUM    = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM-1:0]    hit_o
);
  localparam int STRIDE = 4;

  for (genvar i = 0; i < NUM; i++) begin : g_hit
    assign hit_o[i] = (addr_i == ADDR_W'(i * STRIDE));
  end
endmodule

// File: rtl/cmp_reg_word.sv
module cmp_reg_word
  import cmp_regs_pkg::*;
#(
  parameter int INP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic              lock_o
);
  cfg_t cfg_q;
  logic lock_q;

  // once locked, the whole word including lock ignores writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
    end else if (we_i && !lock_q) begin
      cfg_q.blank    <= wdata_i[BLANK_LSB +: BLANK_W];
      cfg_q.pwr      <= wdata_i[PWR_LSB +: 2];
      cfg_q.hyst     <= wdata_i[HYST_LSB +: 2];
      cfg_q.pol      <= wdata_i[POL_BIT];
      cfg_q.win_out  <= wdata_i[WOUT_BIT];
      cfg_q.win_mode <= wdata_i[WMODE_BIT];
      cfg_q.inp      <= INP_MAX_W'(wdata_i[INP_LSB +: INP_W]);
      cfg_q.inm      <= wdata_i[INM_LSB +: INM_W];
      cfg_q.en       <= wdata_i[EN_BIT];
      lock_q         <= wdata_i[LOCK_BIT];
    end
  end

  assign cfg_o  = cfg_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/cmp_rd_mux.sv
module cmp_rd_mux
  import cmp_regs_pkg::*;
#(
  parameter int NUM = 2
) (
  input  logic [NUM-1:0]             hit_i,
  input  logic [NUM-1:0][WORD_W-1:0] word_i,
  output logic [WORD_W-1:0]          rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (hit_i[i]) rdata_o = rdata_o | word_i[i];
    end
  end
endmodule

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
  import cmp_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        wr_en_i,
  input  logic [WORD_W-1:0]           wdata_i,
  output logic [WORD_W-1:0]           rdata_o,
  input  logic [NUM_CH-1:0]           stat_i,
  output logic [NUM_CH-1:0]           en_o,
  output logic [NUM_CH*INP_MAX_W-1:0] inp_sel_o,
  output logic [NUM_CH*INM_W-1:0]     inm_sel_o,
  output logic [NUM_CH-1:0]           win_mode_o,
  output logic [NUM_CH-1:0]           win_out_o,
  output logic [NUM_CH-1:0]           pol_o,
  output logic [NUM_CH*2-1:0]         hyst_o,
  output logic [NUM_CH*2-1:0]         pwr_o,
  output logic [NUM_CH*BLANK_W-1:0]   blank_o,
  output logic [NUM_CH-1:0]           lock_o
);
  logic [NUM_CH-1:0]             hit;
  logic [NUM_CH-1:0][WORD_W-1:0] word;
  cfg_t                          cfg [NUM_CH];

  cmp_addr_dec #(.ADDR_W(ADDR_W), .NUM(NUM_CH)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // channel 1 has a narrower non-inverting selector
    localparam int INP_W = (i == 0) ? 3 : 2;

    cmp_reg_word #(.INP_W(INP_W)) u_word (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && hit[i]),
      .wdata_i (wdata_i),
      .cfg_o   (cfg[i]),
      .lock_o  (lock_o[i])
    );

    assign word[i] = pack_word(cfg[i], lock_o[i], stat_i[i]);

    assign en_o[i]                         = cfg[i].en;
    assign inp_sel_o[i*INP_MAX_W +: INP_MAX_W] = cfg[i].inp;
    assign inm_sel_o[i*INM_W +: INM_W]     = cfg[i].inm;
    assign win_mode_o[i]                   = cfg[i].win_mode;
    assign win_out_o[i]                    = cfg[i].win_out;
    assign pol_o[i]                        = cfg[i].pol;
    assign hyst_o[i*2 +: 2]                = cfg[i].hyst;
    assign pwr_o[i*2 +: 2]                 = cfg[i].pwr;
    assign blank_o[i*BLANK_W +: BLANK_W]   = cfg[i].blank;
  end

  cmp_rd_mux #(.NUM(NUM_CH)) u_rd (
    .hit_i   (hit),
    .word_i  (word),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/cmp_ctrl_regs_chk.sv
module cmp_ctrl_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [1:0]        stat_i,
  input logic [1:0]        en_o,
  input logic [5:0]        inp_sel_o,
  input logic [7:0]        inm_sel_o,
  input logic [1:0]        win_mode_o,
  input logic [1:0]        win_out_o,
  input logic [1:0]        pol_o,
  input logic [3:0]        hyst_o,
  input logic [3:0]        pwr_o,
  input logic [9:0]        blank_o,
  input logic [1:0]        lock_o
);
  logic unmapped;
  assign unmapped = (addr_i != ADDR_W'(0)) && (addr_i != ADDR_W'(4));

  // R2
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(0) && !lock_o[0]) |=> (en_o[0] == $past(wdata_i[0])));

  // R3
  inp1_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inp_sel_o[5] == 1'b0);

  // R4
  lock0_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o[0] |=> lock_o[0]);

  // R4
  lock1_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o[1] |=> lock_o[1]);

  // R5
  frozen0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o[0] |=> ($stable(en_o[0]) && $stable(inp_sel_o[2:0]) && $stable(inm_sel_o[3:0])
                   && $stable(blank_o[4:0]) && $stable(pwr_o[1:0]) && $stable(hyst_o[1:0])
                   && $stable(pol_o[0]) && $stable(win_out_o[0]) && $stable(win_mode_o[0])));

  // R5
  frozen1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o[1] |=> ($stable(en_o[1]) && $stable(inp_sel_o[5:3]) && $stable(inm_sel_o[7:4])
                   && $stable(blank_o[9:5]) && $stable(pwr_o[3:2]) && $stable(hyst_o[3:2])
                   && $stable(pol_o[1]) && $stable(win_out_o[1]) && $stable(win_mode_o[1])));

  // R7
  indep1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(4) && !lock_o[1]) |=> (en_o[1] == $past(wdata_i[0])));

  // R8
  live_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(0)) |-> (rdata_o[30] == stat_i[0]));

  // R9
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[29:25] == 5'd0) && (rdata_o[13:12] == 2'd0) && (rdata_o[3:1] == 3'd0));

  // R10
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> (rdata_o == 32'd0));

  // R10
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && unmapped) |=> ($stable(en_o) && $stable(lock_o) && $stable(blank_o)
                               && $stable(inm_sel_o) && $stable(inp_sel_o)));
endmodule

bind cmp_ctrl_regs cmp_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cmp_ctrl_regs_tb.sv
`timescale 1ns/1ps
module cmp_ctrl_regs_tb;
  localparam int ADDR_W = 8;
  localparam logic [31:0] MASK0 = 32'h81FF_CFF1;
  localparam logic [31:0] MASK1 = 32'h81FF_CBF1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              wr_en_i = 1'b0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [1:0]        stat_i = '0;
  logic [1:0]        en_o, win_mode_o, win_out_o, pol_o, lock_o;
  logic [5:0]        inp_sel_o;
  logic [7:0]        inm_sel_o;
  logic [3:0]        hyst_o, pwr_o;
  logic [9:0]        blank_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cmp_ctrl_regs #(.ADDR_W(ADDR_W)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8'h00, d); check("R1 word0", d, 32'h0);
    rd(8'h04, d); check("R1 word1", d, 32'h0);
    check("R1 outputs", {en_o, lock_o, blank_o, pwr_o, hyst_o}, 32'h0);
  endtask

  task automatic t_write_fields();
    logic [31:0] d;
    logic [31:0] p;
    do_reset();
    p = 32'h0135_8A61;
    wr(8'h00, p);
    rd(8'h00, d); check("R2 readback pattern A", d, p & MASK0);
    check("R2 blank", 32'(blank_o[4:0]), 32'(p[24:20]));
    check("R2 pwr", 32'(pwr_o[1:0]), 32'(p[19:18]));
    check("R2 hyst", 32'(hyst_o[1:0]), 32'(p[17:16]));
    check("R2 pol/wout/wmode/en", {pol_o[0], win_out_o[0], win_mode_o[0], en_o[0]},
          {p[15], p[14], p[11], p[0]});
    check("R2 inp/inm", {inp_sel_o[2:0], inm_sel_o[3:0]}, {p[10:8], p[7:4]});
    p = 32'h7FFF_FFFF;
    wr(8'h00, p);
    rd(8'h00, d); check("R2 R9 all ones", d, p & MASK0);
    p = 32'h0042_4410;
    wr(8'h00, p);
    rd(8'h00, d); check("R2 readback pattern B", d, p & MASK0);
  endtask

  task automatic t_word1_layout();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h7FFF_FFFF);
    rd(8'h04, d); check("R3 word1 bit10 zero", d, 32'h7FFF_FFFF & MASK1);
    check("R3 inp1 export", 32'(inp_sel_o[5:3]), 32'h3);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    wr(8'h00, 32'h0000_0001);
    wr(8'h00, 32'h8000_0011);
    rd(8'h00, d); check("R4 R6 lock set", d, 32'h8000_0011);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, d); check("R4 lock not cleared", d, 32'h8000_0011);
    wr(8'h00, 32'h01FF_CFF0);
    rd(8'h00, d); check("R5 locked ignored", d, 32'h8000_0011);
    check("R5 outputs frozen", {blank_o[4:0], inm_sel_o[3:0], en_o[0]}, {5'h0, 4'h1, 1'b1});
    do_reset();
    rd(8'h00, d); check("R4 reset clears lock", d, 32'h0);
    wr(8'h00, 32'h0000_0001);
    rd(8'h00, d); check("R4 writable after reset", d, 32'h1);
  endtask

  task automatic t_same_write();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R6 lock plus fields", d, MASK1);
    check("R6 lock_o", 32'(lock_o), 32'h2);
  endtask

  task automatic t_independent();
    logic [31:0] d;
    do_reset();
    wr(8'h00, 32'h8000_0000);
    wr(8'h04, 32'h0123_4567);
    rd(8'h04, d); check("R7 word1 writable", d, 32'h0123_4567 & MASK1);
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, d); check("R7 word1 rewritable", d, 32'h0);
    rd(8'h00, d); check("R7 word0 still locked", d, 32'h8000_0000);
  endtask

  task automatic t_status();
    logic [31:0] d;
    do_reset();
    wr(8'h00, 32'h4000_0000);
    rd(8'h00, d); check("R8 write to bit30 ignored", d, 32'h0);
    stat_i = 2'b01;
    rd(8'h00, d); check("R8 stat0 live", d, 32'h4000_0000);
    rd(8'h04, d); check("R8 stat1 low", d, 32'h0);
    stat_i = 2'b10;
    rd(8'h04, d); check("R8 stat1 live", d, 32'h4000_0000);
    rd(8'h00, d); check("R8 stat0 low", d, 32'h0);
    stat_i = 2'b00;
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    do_reset();
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    stat_i = 2'b11;
    rd(8'h08, d); check("R10 read 0x08", d, 32'h0);
    rd(8'h02, d); check("R10 read 0x02", d, 32'h0);
    rd(8'h00, d); check("R10 word0 untouched", d, 32'h4000_0000);
    rd(8'h04, d); check("R10 word1 untouched", d, 32'h4000_0000);
    stat_i = 2'b00;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_write_fields();
    t_word1_layout();
    t_lock();
    t_same_write();
    t_independent();
    t_status();
    t_unmapped();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule